// File: doc/BRIEF.md
# Prioritised Interrupt Flag Controller

This block sits beside a small 8-bit processor core and turns raw interrupt conditions into one request with a vector index. Each event source has a pending flag that latches a one-cycle event pulse, whether or not that source is enabled. One external source is level-sensitive and has no flag. It requests service only while its input is high and its enable bit is set.

Enable bits live in two mask registers on a simple I/O register port. The pending flags sit at a third address and are cleared by writing ones. A global enable gates every request. The controller drops the global enable itself when the core acknowledges a vector, and sets it again on a return-from-interrupt pulse. The core can also set or clear it directly. The controller does not save or restore any processor status.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, both mask registers, all pending flags and the global enable are zero, and `irq_req` is low.
- R2: An event pulse on `evt[i]` sets pending flag i on the next clock, even when that source's enable bit is zero. The flag stays set until it is cleared.
- R3: A write to address 0x38 clears each flag whose data bit is one. Flag i sits at data bit i. Data bits of zero leave their flags unchanged.
- R4: An `irq_ack` clears the global enable on the next clock. When `irq_vec` is k≥1, the same ack also clears flag k-1 on that clock.
- R5: A `reti` or `gie_set` pulse sets the global enable, and a `gie_clr` pulse clears it. `irq_ack` takes priority over all three, and set takes priority over clear.
- R6: `irq_req` is high exactly when the global enable is one and at least one source is both pending and enabled. `irq_vec` is then the lowest such index. Index 0 is the level source, and index k is flag k-1.
- R7: The level source keeps no flag. It requests vector 0 only while `lvl_req` is high and its enable bit is set, and it leaves the flag register untouched.
- R8: The general mask sits at address 0x3B, and only bit 6 (the level-source enable) is writable. All other bits read zero. The event mask sits at address 0x39, with bit i enabling flag i. Any other address reads zero.
- R9: When an event for source i arrives in the same cycle as a hardware or software clear of flag i, the flag is left set.
- R10: Flags that latch while the global enable is zero are served one at a time in priority order, one per return-from-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | NUM_EVT | One-cycle event pulses, one per flagged source |
| lvl_req | input | 1 | Level-sensitive external request, active high |
| io_addr | input | 6 | I/O register address |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr`, combinational |
| gie_set | input | 1 | Core sets the global enable |
| gie_clr | input | 1 | Core clears the global enable |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_ack | input | 1 | Core has taken the vector shown on `irq_vec` |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Index of the winning source |
| gie | output | 1 | Current global enable |

## Verification
The assertions assume that the core raises `irq_ack` only in a cycle where `irq_req` is high, so the acknowledged index is always a live one. They also assume that `reti` never arrives in the same cycle as an ack. The stimulus follows both rules. It drives `irq_ack` only after the reference model predicts a request, and it issues `reti` in cycles of its own. All other inputs, including events that collide with clears, are free.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int NUM_EVT = 4,
  parameter int AW = 6,
  parameter int DW = 8,
  parameter logic [5:0] GMSK_ADDR = 6'h3B,
  parameter logic [5:0] EMSK_ADDR = 6'h39,
  parameter logic [5:0] FLAG_ADDR = 6'h38,
  parameter int LVL_BIT = 6,
  localparam int VEC_W = $clog2(NUM_EVT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               lvl_req,
  input  logic [AW-1:0]      io_addr,
  input  logic               io_wr,
  input  logic [DW-1:0]      io_wdata,
  output logic [DW-1:0]      io_rdata,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               reti,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               gie
);

  logic [NUM_EVT-1:0] flags, emask, clr;
  logic               lvl_en;
  logic [NUM_EVT:0]   live;

  assign live    = {flags & emask, lvl_req & lvl_en};
  assign irq_req = gie & (|live);

  always_comb begin
    irq_vec = '0;
    for (int i = NUM_EVT; i >= 0; i--)
      if (live[i]) irq_vec = VEC_W'(i);
  end

  always_comb begin
    clr = '0;
    if (io_wr && io_addr == FLAG_ADDR) clr = io_wdata[NUM_EVT-1:0];
    for (int i = 0; i < NUM_EVT; i++)
      if (irq_ack && irq_vec == VEC_W'(i + 1)) clr[i] = 1'b1;
  end

  always_comb begin
    io_rdata = '0;
    if (io_addr == GMSK_ADDR)      io_rdata[LVL_BIT] = lvl_en;
    else if (io_addr == EMSK_ADDR) io_rdata = DW'(emask);
    else if (io_addr == FLAG_ADDR) io_rdata = DW'(flags);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags  <= '0;
      emask  <= '0;
      lvl_en <= 1'b0;
      gie    <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | evt;
      if (io_wr && io_addr == GMSK_ADDR) lvl_en <= io_wdata[LVL_BIT];
      if (io_wr && io_addr == EMSK_ADDR) emask <= io_wdata[NUM_EVT-1:0];
      if (irq_ack)               gie <= 1'b0;
      else if (reti || gie_set)  gie <= 1'b1;
      else if (gie_clr)          gie <= 1'b0;
    end
  end

  // R4
  ack_drops_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !gie);
  // R5
  reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_ack) |=> gie);
  // R9
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));
  // R3
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == FLAG_ADDR && evt == '0) |=> ((flags & $past(io_wdata[NUM_EVT-1:0])) == '0));
  // R7
  lvl_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec == '0) |-> lvl_req);
  // R8
  gmsk_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == GMSK_ADDR) |-> ((io_rdata & ~(DW'(1) << LVL_BIT)) == '0));
  // R6
  req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie) |-> !irq_req);

endmodule

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
  localparam int N = 4;
  localparam int VW = 3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] evt = '0;
  logic lvl_req = 0, io_wr = 0, gie_set = 0, gie_clr = 0, reti = 0, irq_ack = 0;
  logic [5:0] io_addr = '0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic irq_req, gie;
  logic [VW-1:0] irq_vec;

  always #10 clk = ~clk;

  irq_flag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt(evt), .lvl_req(lvl_req), .io_addr(io_addr),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .gie_set(gie_set),
    .gie_clr(gie_clr), .reti(reti), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_vec(irq_vec), .gie(gie)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  bit [N-1:0] m_flags = '0, m_emask = '0;
  bit m_lvl_en = 0, m_gie = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_vec();
    if (lvl_req && m_lvl_en) return 0;
    for (int i = 0; i < N; i++) if (m_flags[i] && m_emask[i]) return i + 1;
    return -1;
  endfunction

  function automatic int exp_rd();
    if (io_addr == 6'h3B) return m_lvl_en ? 8'h40 : 0;
    if (io_addr == 6'h39) return int'(m_emask);
    if (io_addr == 6'h38) return int'(m_flags);
    return 0;
  endfunction

  task automatic step(string req);
    int v;
    bit [N-1:0] c;
    #1;
    v = exp_vec();
    chk(req, "irq_req", int'(irq_req), int'(m_gie && v >= 0));
    if (m_gie && v >= 0) chk(req, "irq_vec", int'(irq_vec), v);
    chk(req, "io_rdata", int'(io_rdata), exp_rd());
    chk(req, "gie", int'(gie), int'(m_gie));
    @(posedge clk);
    c = '0;
    if (io_wr && io_addr == 6'h38) c = io_wdata[N-1:0];
    if (irq_ack && v > 0) c[v-1] = 1'b1;
    m_flags = (m_flags & ~c) | evt;
    if (io_wr && io_addr == 6'h3B) m_lvl_en = io_wdata[6];
    if (io_wr && io_addr == 6'h39) m_emask = io_wdata[N-1:0];
    if (irq_ack) m_gie = 0;
    else if (reti || gie_set) m_gie = 1;
    else if (gie_clr) m_gie = 0;
    @(negedge clk);
    evt = '0; io_wr = 0; gie_set = 0; gie_clr = 0; reti = 0; irq_ack = 0;
  endtask

  task automatic wr(bit [5:0] a, bit [7:0] d, string req);
    io_addr = a; io_wdata = d; io_wr = 1; step(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    io_addr = 6'h38; step("R1");
    io_addr = 6'h39; step("R1");
    // R2 masked event still latches
    evt = 4'b0100; step("R2");
    io_addr = 6'h38; step("R2");
    chk("R2", "flag2", int'(io_rdata[2]), 1);
    // R3 write zero no effect, write one clears
    wr(6'h38, 8'h00, "R3"); io_addr = 6'h38; step("R3");
    wr(6'h38, 8'h04, "R3"); io_addr = 6'h38; step("R3");
    chk("R3", "flags", int'(io_rdata), 0);
    // R10 latched while gie low, served in order
    wr(6'h39, 8'hFF, "R8"); io_addr = 6'h39; step("R8");
    evt = 4'b1010; step("R10");
    step("R6");
    gie_set = 1; step("R5");
    chk("R6", "vec", int'(irq_vec), 2);
    irq_ack = 1; step("R4");
    io_addr = 6'h38; step("R4");
    reti = 1; step("R10");
    chk("R10", "vec", int'(irq_vec), 4);
    irq_ack = 1; step("R4");
    reti = 1; step("R5");
    // R8 reserved general mask bits
    wr(6'h3B, 8'hFF, "R8"); io_addr = 6'h3B; step("R8");
    chk("R8", "gmsk", int'(io_rdata), 8'h40);
    // R7 level source
    lvl_req = 1; step("R7");
    chk("R7", "vec", int'(irq_vec), 0);
    io_addr = 6'h38; step("R7");
    lvl_req = 0; step("R7");
    irq_ack = 0; lvl_req = 1; irq_ack = 1; step("R7");
    lvl_req = 0; reti = 1; step("R5");
    // R9 set wins over hardware clear and software clear
    evt = 4'b0001; step("R9");
    evt = 4'b0001; irq_ack = 1; step("R9");
    io_addr = 6'h38; step("R9");
    chk("R9", "flag0", int'(io_rdata[0]), 1);
    evt = 4'b0001; wr(6'h38, 8'h01, "R9");
    io_addr = 6'h38; step("R9");
    chk("R9", "flag0 sw", int'(io_rdata[0]), 1);
    // R5 clear and priority
    gie_set = 1; gie_clr = 1; step("R5");
    gie_clr = 1; step("R5");
    step("R6");
    io_addr = 6'h10; step("R8");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule